// File: doc/BRIEF.md
# Priority Interrupt Controller

This block arbitrates eight hardware interrupt request lines onto a single interrupt line to a processor. Requests are captured into a request register every clock and filtered through a software-written mask. The lowest-numbered unmasked captured request wins. The controller raises `int_o`. When the processor acknowledges, the controller returns an 8-bit vector equal to a programmable base plus the winning line's index.

Service is strictly non-preemptive. Once a line has been acknowledged, its in-service bit is set, and no further interrupt is raised until software writes the end-of-service command, even for a higher-priority line. Requests that arrive in the meantime stay latched and are served after that command.

Software uses a two-address register port (command and mask) plus a separate configuration strobe that loads the vector base.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset `int_o` and `vec_oe_o` are low, the mask reads 00h, the in-service state reads 00h and the vector base is 08h, so an acknowledged IRQ0 yields vector 08h.
- R2: When several unmasked requests are captured, the lowest index (IRQ0 highest, IRQ7 lowest) is served first.
- R3: `int_o` is high exactly when nothing is in service and at least one captured request is unmasked; a request sampled on a clock edge shows on `int_o` right after that edge.
- R4: `inta_i` high at a clock edge while `int_o` is high causes the following: `vec_oe_o` is high for the next cycle only, with `vec_o` = base + index. The line's request bit is cleared, its in-service bit is set and `int_o` falls.
- R5: A `cfg_we_i` write loads the vector base from `wdata_i[7:3]` with bits 2:0 forced to zero (writing 75h gives base 70h).
- R6: While any in-service bit is set, `int_o` stays low and the in-service state does not change, even if a higher-priority request arrives.
- R7: A write of 20h to address 0 clears the in-service state. Any other value written to address 0 has no effect.
- R8: A write to address 1 loads the mask, where bit i = 1 blocks IRQ i. The mask reads back at address 1. A blocked request stays captured and is served once its mask bit is cleared.
- R9: A request pulse of a single clock is held in the request register until it is acknowledged.
- R10: `inta_i` while `int_o` is low is ignored: no vector is driven and the in-service state is unchanged.
- R11: A read at address 0 returns the in-service state, where bit i = 1 means IRQ i is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 8 | Request lines, bit i = IRQ i |
| inta_i | input | 1 | Interrupt acknowledge from the processor |
| we_i | input | 1 | Register port write strobe |
| addr_i | input | 1 | Register address: 0 command / in-service, 1 mask |
| wdata_i | input | 8 | Write data for register port and base configuration |
| cfg_we_i | input | 1 | Vector base write strobe |
| rdata_o | output | 8 | Read data at `addr_i` |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Vector number |
| vec_oe_o | output | 1 | Vector drive enable, one cycle after acknowledge |

## Verification
The assertions assume the processor raises `inta_i` only in response to `int_o`. A stray acknowledge is still expected to be dropped without side effects. They also assume software issues the end-of-service command only while a line is in service, or at least not together with a new acknowledge. The bench drives acknowledges as single-cycle pulses and only after sampling `int_o` high, except in the one scenario that deliberately probes a stray acknowledge. It also writes the end-of-service command only after the vector cycle has completed.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned IRQ_N   = 8;
  localparam int unsigned VEC_W   = 8;
  localparam logic [7:0]  EOI_CMD = 8'h20;
  localparam logic [7:0]  BASE_RST = 8'h08;

  typedef enum logic {
    ADDR_CMD  = 1'b0,
    ADDR_MASK = 1'b1
  } reg_addr_e;
endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = 3
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // scan downward so the lowest index wins
  always_comb begin
    gnt_o = '0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/irq_cfg_port.sv
module irq_cfg_port
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned VW = 8,
  parameter int unsigned IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          addr_i,
  input  logic [VW-1:0] wdata_i,
  input  logic          cfg_we_i,
  input  logic [N-1:0]  isr_i,
  output logic [N-1:0]  mask_o,
  output logic [VW-1:0] base_o,
  output logic          eoi_o,
  output logic [VW-1:0] rdata_o
);
  logic [N-1:0]  mask_q;
  logic [VW-1:0] base_q;

  assign eoi_o = we_i && (addr_i == ADDR_CMD) && (wdata_i == VW'(EOI_CMD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      base_q <= VW'(BASE_RST);
    end else begin
      if (we_i && addr_i == ADDR_MASK) mask_q <= wdata_i[N-1:0];
      if (cfg_we_i) base_q <= {wdata_i[VW-1:IW], {IW{1'b0}}};
    end
  end

  assign mask_o  = mask_q;
  assign base_o  = base_q;
  assign rdata_o = (addr_i == ADDR_MASK) ? VW'(mask_q) : VW'(isr_i);
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N  = IRQ_N,
  parameter int unsigned VW = VEC_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic          inta_i,
  input  logic          we_i,
  input  logic          addr_i,
  input  logic [VW-1:0] wdata_i,
  input  logic          cfg_we_i,
  output logic [VW-1:0] rdata_o,
  output logic          int_o,
  output logic [VW-1:0] vec_o,
  output logic          vec_oe_o
);
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]  irr_q, isr_q, mask, pending, gnt;
  logic [IW-1:0] idx;
  logic [VW-1:0] base, vec_q;
  logic          any, in_svc, ack, eoi, vec_oe_q;

  irq_cfg_port #(.N(N), .VW(VW), .IW(IW)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .cfg_we_i(cfg_we_i),
    .isr_i   (isr_q),
    .mask_o  (mask),
    .base_o  (base),
    .eoi_o   (eoi),
    .rdata_o (rdata_o)
  );

  assign pending = irr_q & ~mask;

  irq_pick #(.N(N), .IW(IW)) u_pick (
    .req_i(pending),
    .gnt_o(gnt),
    .idx_o(idx),
    .any_o(any)
  );

  assign in_svc = |isr_q;
  assign int_o  = !in_svc && any;
  assign ack    = inta_i && int_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q    <= '0;
      isr_q    <= '0;
      vec_q    <= '0;
      vec_oe_q <= 1'b0;
    end else begin
      irr_q    <= (irr_q | irq_i) & ~(ack ? gnt : '0);
      vec_oe_q <= ack;
      if (ack) begin
        isr_q <= gnt;
        vec_q <= base + VW'(idx);
      end else if (eoi) begin
        isr_q <= '0;
      end
    end
  end

  assign vec_o    = vec_q;
  assign vec_oe_o = vec_oe_q;

  // R2: grant never skips a lower-index pending line
  assert_prio_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any |-> (((pending & (gnt - 1'b1)) == '0) && $onehot(gnt)));

  assert_ack_vec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && int_o) |=> (vec_oe_o && isr_q[vec_o[IW-1:0]] && !int_o &&
                           vec_o[VW-1:IW] == $past(base[VW-1:IW])));

  assert_isr_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(isr_q));

  assert_hold_isr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_svc && !eoi) |=> $stable(isr_q));

  assert_eoi_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !ack) |=> (isr_q == '0));

  assert_spurious_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inta_i && !int_o) |=> (!vec_oe_o && $stable(isr_q)));
endmodule

// File: tb/tb_irq_ctrl_top.sv
`timescale 1ns/1ps
module tb_irq_ctrl_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       inta = 1'b0, we = 1'b0, addr = 1'b0, cfg_we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, vec;
  logic       intr, vec_oe;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  irq_ctrl_top dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .inta_i(inta),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .cfg_we_i(cfg_we),
    .rdata_o(rdata), .int_o(intr), .vec_o(vec), .vec_oe_o(vec_oe)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_irq(logic [7:0] v);
    irq = v; step(); irq = '0;
  endtask

  task automatic wr(logic a, logic [7:0] d);
    we = 1'b1; addr = a; wdata = d; step(); we = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    addr = a; #1 d = rdata; addr = 1'b0;
  endtask

  // acknowledge, check vector and one-cycle enable
  task automatic ack_expect(string req, logic [7:0] exp_vec);
    check(req, 8'(intr), 8'h1);
    inta = 1'b1; step(); inta = 1'b0;
    check(req, 8'(vec_oe), 8'h1);
    check(req, vec, exp_vec);
    check(req, 8'(intr), 8'h0);
    step();
    check(req, 8'(vec_oe), 8'h0);
  endtask

  task automatic eoi();
    wr(1'b0, 8'h20);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 int", 8'(intr), 8'h0);
    check("R1 vec_oe", 8'(vec_oe), 8'h0);
    rd(1'b1, d); check("R1 mask", d, 8'h00);
    rd(1'b0, d); check("R1 isr", d, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    pulse_irq(8'h01);
    check("R3 int after sample", 8'(intr), 8'h1);
    ack_expect("R1 default base", 8'h08);
    eoi();
    pulse_irq(8'h08);
    step(); step();
    check("R9 pulse held", 8'(intr), 8'h1);
    ack_expect("R4 vector", 8'h0B);
    rd(1'b0, d); check("R11 isr read", d, 8'h08);
    eoi();
    rd(1'b0, d); check("R7 eoi clears", d, 8'h00);
    check("R3 idle", 8'(intr), 8'h0);
  endtask

  task automatic t_prio();
    pulse_irq(8'hA4);
    ack_expect("R2 first", 8'h0A);
    eoi();
    ack_expect("R2 second", 8'h0D);
    eoi();
    ack_expect("R2 third", 8'h0F);
    eoi();
    check("R2 drained", 8'(intr), 8'h0);
  endtask

  task automatic t_nonpreempt();
    logic [7:0] d;
    pulse_irq(8'h40);
    ack_expect("R6 low prio", 8'h0E);
    pulse_irq(8'h01);
    step(); step();
    check("R6 no preempt", 8'(intr), 8'h0);
    rd(1'b0, d); check("R6 isr held", d, 8'h40);
    wr(1'b0, 8'h11);
    check("R7 bad cmd int", 8'(intr), 8'h0);
    rd(1'b0, d); check("R7 bad cmd isr", d, 8'h40);
    eoi();
    check("R7 eoi releases", 8'(intr), 8'h1);
    ack_expect("R6 served after", 8'h08);
    eoi();
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(1'b1, 8'h02);
    rd(1'b1, d); check("R8 readback", d, 8'h02);
    pulse_irq(8'h02);
    check("R8 blocked", 8'(intr), 8'h0);
    pulse_irq(8'h10);
    ack_expect("R8 skip masked", 8'h0C);
    eoi();
    check("R8 still blocked", 8'(intr), 8'h0);
    wr(1'b1, 8'h00);
    ack_expect("R8 unmask", 8'h09);
    eoi();
  endtask

  task automatic t_base();
    cfg_we = 1'b1; wdata = 8'h75; step(); cfg_we = 1'b0;
    pulse_irq(8'h04);
    ack_expect("R5 base", 8'h72);
    eoi();
    pulse_irq(8'h80);
    ack_expect("R5 top line", 8'h77);
    eoi();
    cfg_we = 1'b1; wdata = 8'h08; step(); cfg_we = 1'b0;
  endtask

  task automatic t_spurious();
    logic [7:0] d;
    check("R10 idle", 8'(intr), 8'h0);
    inta = 1'b1; step(); inta = 1'b0;
    check("R10 no vec", 8'(vec_oe), 8'h0);
    rd(1'b0, d); check("R10 isr", d, 8'h00);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_basic();
    t_prio();
    t_nonpreempt();
    t_mask();
    t_base();
    t_spurious();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule